// File: doc/BRIEF.md
# Region Coherence State Controller

This block holds the decision logic for one entry of a coarse-grain region tracking array. A region is an aligned group of cache lines. Its state records two things: whether this node holds clean or possibly modified lines of the region, and whether other nodes hold none, only clean, or possibly modified lines of it. The array itself lives outside the block. The block reads the stored state and the line count for the addressed region, and it returns the value to write back.

For a local request, the block decides in the same cycle whether the request must be broadcast or can go straight to memory. When the request is broadcast, the block folds the region-level snoop response into the new state. This can upgrade the region to an exclusive or externally clean state. For an external snoop, the block downgrades the remote half of the state. It also produces this node's two region response bits. When the region holds no cached lines, it self-invalidates the entry so that a later local request can regain exclusivity.

Top module: `rgn_coh_ctrl`

## Requirements
- R1: States use a 3-bit code: I=000, CI=001, CC=010, CD=011, DI=101, DC=110, DD=111. Bit 2 means local lines may be modified. Bits [1:0] give remote status (01 none, 10 clean, 11 dirty, 00 region invalid). An input state of 100 is treated as I. Request codes are: fetch=0, shared read=1, exclusive read=2, read-for-ownership=3, write-back=4, region eviction=5. Codes 6 and 7 leave the state unchanged and are never broadcast.
- R2: `bcast_o` is combinational from `st_rd_i` and `req_op_i`, and only codes 0 to 3 can raise it. It is always 1 in I, CD and DD. It is always 0 in CI and DI. In CC and DC it is 1 only for codes 2 and 3. Write-back and eviction give 0.
- R3: From I, codes 0 and 1 give local-clean and codes 2 and 3 give local-dirty. The remote field comes from the response: none→01, clean→10, dirty→11. A response with both bits set counts as dirty. If no response is supplied, the remote field is taken as dirty.
- R4: Codes 2 and 3 in a clean-local state move to the matching dirty-local state. CI goes to DI without a broadcast, and its remote field is unchanged.
- R5: On a broadcast request with `rsp_valid_i`, the response replaces the remote field in either direction. For example, CC with a read-for-ownership and an empty response goes to DI. When the request is not broadcast, the response is ignored.
- R6: A local write-back leaves the state unchanged. A local eviction writes I.
- R7: An external fetch or shared read, or an exclusive read with `snp_shared_i`, turns remote-none into remote-clean and leaves the other states as they are. An external exclusive read without the hint, or a read-for-ownership, makes the remote field dirty. The local bit never changes on a snoop. An external write-back or eviction leaves the state unchanged.
- R8: A snoop that hits a valid region whose `lcnt_i` is 0 writes I and answers with both response bits at 0.
- R9: For a snoop, `snp_clean_o` and `snp_dirty_o` appear one cycle later. In I, or when the region is empty, both are 0. Otherwise exactly one is set: clean for local-clean states, dirty for local-dirty states. Both bits are 0 in every cycle that does not follow a snoop.
- R10: `wr_valid_o` pulses one cycle after each request or snoop, carrying `wr_state_o`. When a request and a snoop arrive in the same cycle, the snoop's update is written and the request's update is dropped.
- R11: While and after reset, with no event, `wr_valid_o`, `snp_clean_o` and `snp_dirty_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_rd_i | input | 3 | Region state read from the array |
| lcnt_i | input | CNT_W | Count of this node's cached lines in the region |
| req_valid_i | input | 1 | Local request present |
| req_op_i | input | 3 | Local request code |
| rsp_valid_i | input | 1 | Region snoop response accompanies the request |
| rsp_clean_i | input | 1 | Others hold clean lines of the region |
| rsp_dirty_i | input | 1 | Others may hold modified lines of the region |
| snp_valid_i | input | 1 | External snoop present |
| snp_op_i | input | 3 | External request code |
| snp_shared_i | input | 1 | External exclusive read is known to get a shared line |
| bcast_o | output | 1 | Local request must be broadcast |
| wr_valid_o | output | 1 | State write-back to the array |
| wr_state_o | output | 3 | New region state |
| snp_clean_o | output | 1 | This node's region-clean response |
| snp_dirty_o | output | 1 | This node's region-dirty response |

## Verification
The main function is first driven with directed sequences. These walk each state through fetch, shared, exclusive and ownership requests with each of the four response encodings. This separates response-driven upgrades from the silent CI-to-DI change and from ignored responses on direct requests. Snoops are then applied with each request code, with and without the shared hint, and with zero and non-zero line counts. These cases separate clean downgrades, dirty downgrades and self-invalidation. A seeded random mix of requests, snoops, collisions and idle cycles covers the remaining combinations, including the unused state code 100.

// File: rtl/rgn_coh_pkg.sv
package rgn_coh_pkg;
  localparam int unsigned ST_W = 3;
  typedef logic [ST_W-1:0] rgn_st_t;

  localparam rgn_st_t ST_I  = 3'b000;
  localparam rgn_st_t ST_CI = 3'b001;
  localparam rgn_st_t ST_CC = 3'b010;
  localparam rgn_st_t ST_CD = 3'b011;
  localparam rgn_st_t ST_DI = 3'b101;
  localparam rgn_st_t ST_DC = 3'b110;
  localparam rgn_st_t ST_DD = 3'b111;

  typedef enum logic [1:0] {
    REM_INV   = 2'd0,
    REM_NONE  = 2'd1,
    REM_CLEAN = 2'd2,
    REM_DIRTY = 2'd3
  } rem_e;

  typedef enum logic [2:0] {
    OP_IFETCH = 3'd0,
    OP_RD_S   = 3'd1,
    OP_RD_X   = 3'd2,
    OP_RFO    = 3'd3,
    OP_WB     = 3'd4,
    OP_EVICT  = 3'd5
  } op_e;

  function automatic rgn_st_t st_norm(rgn_st_t s);
    return (s[1:0] == 2'b00) ? ST_I : s;
  endfunction

  function automatic rem_e rem_of(rgn_st_t s);
    return rem_e'(s[1:0]);
  endfunction

  function automatic logic op_is_access(logic [2:0] op);
    return op <= OP_RFO;
  endfunction

  function automatic logic op_wants_mod(logic [2:0] op);
    return (op == OP_RD_X) || (op == OP_RFO);
  endfunction

  // dirty dominates a response with both bits set
  function automatic rem_e rsp_rem(logic cln, logic drt);
    if (drt) return REM_DIRTY;
    if (cln) return REM_CLEAN;
    return REM_NONE;
  endfunction

  function automatic rgn_st_t mk_st(logic ldirty, rem_e rem);
    return {ldirty, rem};
  endfunction
endpackage

// File: rtl/rgn_route.sv
module rgn_route
  import rgn_coh_pkg::*;
(
  input  rgn_st_t    st_i,
  input  logic [2:0] op_i,
  output logic       bcast_o
);
  always_comb begin
    bcast_o = 1'b0;
    if (op_is_access(op_i)) begin
      case (rem_of(st_i))
        REM_INV, REM_DIRTY: bcast_o = 1'b1;
        REM_NONE:           bcast_o = 1'b0;
        REM_CLEAN:          bcast_o = op_wants_mod(op_i);
        default:            bcast_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rgn_local_nxt.sv
module rgn_local_nxt
  import rgn_coh_pkg::*;
(
  input  rgn_st_t    st_i,
  input  logic [2:0] op_i,
  input  logic       bcast_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_clean_i,
  input  logic       rsp_dirty_i,
  output rgn_st_t    nxt_o
);
  logic cur_v;
  logic cur_ld;
  logic new_ld;
  rem_e new_rem;

  assign cur_v  = (rem_of(st_i) != REM_INV);
  assign cur_ld = st_i[2] & cur_v;

  always_comb begin
    new_ld  = op_wants_mod(op_i) | cur_ld;
    if (bcast_i && rsp_valid_i) new_rem = rsp_rem(rsp_clean_i, rsp_dirty_i);
    else if (!cur_v)            new_rem = REM_DIRTY; // nothing known about others
    else                        new_rem = rem_of(st_i);
  end

  always_comb begin
    if (op_is_access(op_i)) nxt_o = mk_st(new_ld, new_rem);
    else if (op_i == OP_EVICT) nxt_o = ST_I;
    else nxt_o = st_i;
  end
endmodule

// File: rtl/rgn_snoop_nxt.sv
module rgn_snoop_nxt
  import rgn_coh_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  rgn_st_t          st_i,
  input  logic [2:0]       op_i,
  input  logic             shared_i,
  input  logic [CNT_W-1:0] lcnt_i,
  output rgn_st_t          nxt_o,
  output logic             rsp_clean_o,
  output logic             rsp_dirty_o
);
  logic live;
  rem_e rem_cur;
  rem_e rem_new;
  logic rd_clean;

  assign rem_cur  = rem_of(st_i);
  assign live     = (rem_cur != REM_INV) && (lcnt_i != '0);
  assign rd_clean = (op_i == OP_IFETCH) || (op_i == OP_RD_S) ||
                    ((op_i == OP_RD_X) && shared_i);

  always_comb begin
    rem_new = rem_cur;
    if (rd_clean) begin
      if (rem_cur == REM_NONE) rem_new = REM_CLEAN;
    end else if (op_wants_mod(op_i)) begin
      rem_new = REM_DIRTY;
    end
  end

  always_comb begin
    if (live) begin
      nxt_o       = mk_st(st_i[2], rem_new);
      rsp_clean_o = ~st_i[2];
      rsp_dirty_o = st_i[2];
    end else begin
      nxt_o       = ST_I; // invalid or empty region
      rsp_clean_o = 1'b0;
      rsp_dirty_o = 1'b0;
    end
  end
endmodule

// File: rtl/rgn_coh_ctrl.sv
module rgn_coh_ctrl
  import rgn_coh_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       st_rd_i,
  input  logic [CNT_W-1:0] lcnt_i,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_clean_i,
  input  logic             rsp_dirty_i,
  input  logic             snp_valid_i,
  input  logic [2:0]       snp_op_i,
  input  logic             snp_shared_i,
  output logic             bcast_o,
  output logic             wr_valid_o,
  output logic [2:0]       wr_state_o,
  output logic             snp_clean_o,
  output logic             snp_dirty_o
);
  rgn_st_t st_n;
  rgn_st_t loc_nxt;
  rgn_st_t snp_nxt;
  logic    snp_c;
  logic    snp_d;

  assign st_n = st_norm(st_rd_i);

  rgn_route i_route (
    .st_i    (st_n),
    .op_i    (req_op_i),
    .bcast_o (bcast_o)
  );

  rgn_local_nxt i_local (
    .st_i        (st_n),
    .op_i        (req_op_i),
    .bcast_i     (bcast_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_clean_i (rsp_clean_i),
    .rsp_dirty_i (rsp_dirty_i),
    .nxt_o       (loc_nxt)
  );

  rgn_snoop_nxt #(.CNT_W(CNT_W)) i_snoop (
    .st_i        (st_n),
    .op_i        (snp_op_i),
    .shared_i    (snp_shared_i),
    .lcnt_i      (lcnt_i),
    .nxt_o       (snp_nxt),
    .rsp_clean_o (snp_c),
    .rsp_dirty_o (snp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o  <= 1'b0;
      wr_state_o  <= ST_I;
      snp_clean_o <= 1'b0;
      snp_dirty_o <= 1'b0;
    end else begin
      wr_valid_o  <= snp_valid_i | req_valid_i;
      snp_clean_o <= snp_valid_i & snp_c;
      snp_dirty_o <= snp_valid_i & snp_d;
      if (snp_valid_i)      wr_state_o <= snp_nxt; // snoop wins a collision
      else if (req_valid_i) wr_state_o <= loc_nxt;
    end
  end

  AST_EXCL_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i <= OP_RFO && (st_rd_i == ST_CI || st_rd_i == ST_DI)) |-> !bcast_o); // R2
  AST_INV_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i <= OP_RFO && st_rd_i[1:0] == 2'b00) |-> bcast_o); // R2
  AST_WR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_state_o != 3'b100)); // R1
  AST_SELF_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && lcnt_i == '0) |=> (wr_valid_o && wr_state_o == ST_I && !snp_clean_o && !snp_dirty_o)); // R8
  AST_SNP_NOT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && st_rd_i[1:0] != 2'b00 && lcnt_i != '0 && snp_op_i <= OP_RFO)
      |=> (wr_state_o[1:0] != 2'b01)); // R7
  AST_RSP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({snp_clean_o, snp_dirty_o})); // R9
  AST_RSP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |=> (!snp_clean_o && !snp_dirty_o)); // R9
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snp_valid_i && !req_valid_i) |=> !wr_valid_o); // R10
endmodule

// File: tb/test_rgn_coh_ctrl.sv
module test_rgn_coh_ctrl;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] st_rd = '0;
  logic [CNT_W-1:0] lcnt = '0;
  logic req_v = 0, rsp_v = 0, rsp_c = 0, rsp_d = 0;
  logic [2:0] req_op = '0;
  logic snp_v = 0, snp_sh = 0;
  logic [2:0] snp_op = '0;
  logic bcast, wr_v, snp_co, snp_do;
  logic [2:0] wr_st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rgn_coh_ctrl #(.CNT_W(CNT_W)) i_rgn_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .st_rd_i(st_rd), .lcnt_i(lcnt),
    .req_valid_i(req_v), .req_op_i(req_op), .rsp_valid_i(rsp_v),
    .rsp_clean_i(rsp_c), .rsp_dirty_i(rsp_d), .snp_valid_i(snp_v),
    .snp_op_i(snp_op), .snp_shared_i(snp_sh), .bcast_o(bcast),
    .wr_valid_o(wr_v), .wr_state_o(wr_st), .snp_clean_o(snp_co), .snp_dirty_o(snp_do)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic [2:0] ref_norm(input [2:0] s);
    return (s == 3'b100) ? 3'b000 : s;
  endfunction

  function automatic bit ref_bcast(input [2:0] s0, input [2:0] op);
    if (op > 3) return 0;
    case (ref_norm(s0))
      3'b001, 3'b101: return 0;
      3'b010, 3'b110: return op >= 2;
      default:        return 1;
    endcase
  endfunction

  function automatic [2:0] ref_local(input [2:0] s0, input [2:0] op, input bit rv, rc, rd);
    logic [2:0] s;
    bit ld;
    logic [1:0] r;
    s = ref_norm(s0);
    if (op == 5) return 3'b000;
    if (op > 3) return s;
    ld = (s == 3'b101 || s == 3'b110 || s == 3'b111);
    r = s[1:0];
    if (op == 2 || op == 3) ld = 1;
    if (ref_bcast(s, op) && rv) r = rd ? 2'd3 : (rc ? 2'd2 : 2'd1);
    else if (s == 3'b000) r = 2'd3;
    return {ld, r};
  endfunction

  function automatic [4:0] ref_snoop(input [2:0] s0, input [2:0] op, input bit sh, input int cnt);
    logic [2:0] s;
    logic [1:0] r;
    s = ref_norm(s0);
    if (s == 3'b000 || cnt == 0) return 5'b000_00;
    r = s[1:0];
    if (op <= 1 || (op == 2 && sh)) begin
      if (r == 2'd1) r = 2'd2;
    end else if (op == 2 || op == 3) r = 2'd3;
    return {s[2], r, ~s[2], s[2]};
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic step(input bit rv, input [2:0] rop, input bit pv, pc, pd,
                      input bit sv, input [2:0] sop, input bit sh,
                      input [2:0] st, input int cnt, input string tag);
    logic [2:0] exp_st;
    logic [4:0] sn;
    req_v = rv; req_op = rop; rsp_v = pv; rsp_c = pc; rsp_d = pd;
    snp_v = sv; snp_op = sop; snp_sh = sh; st_rd = st; lcnt = CNT_W'(cnt);
    #1;
    if (rv) chk(bcast === ref_bcast(st, rop), {tag, " bcast"}, int'(bcast), int'(ref_bcast(st, rop)));
    sn = ref_snoop(st, sop, sh, cnt);
    exp_st = sv ? sn[4:2] : ref_local(st, rop, pv, pc, pd);
    @(negedge clk);
    chk(wr_v === (rv | sv), {tag, " wr_valid"}, int'(wr_v), int'(rv | sv));
    if (rv | sv) chk(wr_st === exp_st, {tag, " state"}, int'(wr_st), int'(exp_st));
    chk({snp_co, snp_do} === (sv ? sn[1:0] : 2'b00), {tag, " rsp"}, int'({snp_co, snp_do}),
        int'(sv ? sn[1:0] : 2'b00));
    req_v = 0; snp_v = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(wr_v === 0 && snp_co === 0 && snp_do === 0, "R11 in reset", int'({wr_v, snp_co, snp_do}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_v === 0 && snp_co === 0 && snp_do === 0, "R11 after reset", int'({wr_v, snp_co, snp_do}), 0);

    step(1, 0, 1, 0, 0, 0, 0, 0, 3'b000, 1, "R3 I fetch none->CI");
    step(1, 1, 1, 1, 0, 0, 0, 0, 3'b000, 1, "R3 I rds clean->CC");
    step(1, 1, 1, 0, 1, 0, 0, 0, 3'b000, 1, "R3 I rds dirty->CD");
    step(1, 3, 1, 1, 1, 0, 0, 0, 3'b000, 1, "R3 I rfo both->DD");
    step(1, 2, 0, 0, 0, 0, 0, 0, 3'b000, 1, "R3 I rdx no rsp->DD");
    step(1, 1, 0, 0, 0, 0, 0, 0, 3'b100, 1, "R1 code 100 as I");
    step(1, 6, 0, 0, 0, 0, 0, 0, 3'b010, 1, "R1 unused op");
    step(1, 3, 0, 0, 0, 0, 0, 0, 3'b001, 1, "R4 CI rfo silent->DI");
    step(1, 2, 1, 1, 0, 0, 0, 0, 3'b010, 1, "R4 CC rdx->DC");
    step(1, 3, 1, 0, 0, 0, 0, 0, 3'b010, 1, "R5 CC rfo upgrade->DI");
    step(1, 0, 1, 1, 0, 0, 0, 0, 3'b011, 1, "R5 CD fetch->CC");
    step(1, 1, 1, 0, 1, 0, 0, 0, 3'b001, 1, "R5 CI rsp ignored");
    step(1, 0, 1, 0, 1, 0, 0, 0, 3'b110, 1, "R2 DC fetch direct");
    step(1, 4, 1, 0, 0, 0, 0, 0, 3'b101, 1, "R6 DI writeback");
    step(1, 5, 0, 0, 0, 0, 0, 0, 3'b111, 1, "R6 DD evict->I");
    step(0, 0, 0, 0, 0, 1, 1, 0, 3'b001, 2, "R7 R9 snoop rds CI->CC");
    step(0, 0, 0, 0, 0, 1, 2, 1, 3'b101, 2, "R7 snoop rdx shared DI->DC");
    step(0, 0, 0, 0, 0, 1, 3, 0, 3'b101, 2, "R7 snoop rfo DI->DD");
    step(0, 0, 0, 0, 0, 1, 2, 0, 3'b010, 2, "R7 snoop rdx CC->CD");
    step(0, 0, 0, 0, 0, 1, 4, 0, 3'b110, 2, "R7 snoop wb no change");
    step(0, 0, 0, 0, 0, 1, 1, 0, 3'b111, 0, "R8 empty DD->I");
    step(0, 0, 0, 0, 0, 1, 0, 0, 3'b000, 3, "R9 snoop in I");
    step(1, 3, 1, 0, 0, 1, 0, 0, 3'b010, 3, "R10 collision snoop wins");
    step(0, 0, 0, 0, 0, 0, 0, 0, 3'b010, 3, "R10 idle");

    for (int i = 0; i < 4000; i++) begin
      int k;
      bit rv, sv;
      logic [2:0] st;
      k = $urandom_range(0, 99);
      rv = (k < 55) || (k >= 90 && k < 95);
      sv = (k >= 55 && k < 95);
      st = 3'($urandom_range(0, 7));
      step(rv, 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom),
           sv, 3'($urandom_range(0, 7)), 1'($urandom), st,
           ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 15), "random R2 R7 R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule